// File: doc/BRIEF.md
# Serial Flash Sector Erase Qualifier

This block watches the serial command stream of a flash device and decides whether a sector erase request is allowed to run. A one-byte write-enable command arms a write-enable latch. A sector erase command carries a 24-bit address, most significant bit first. It runs only when the latch is already armed, no erase is in progress, and chip select rises exactly at the end of the last address bit. When accepted, the block raises a busy flag and writes all-ones bytes through a memory write port across the 4 KiB sector that holds the address. It then keeps busy for the rest of a fixed erase time.

Any address inside a sector selects that sector. The sector number is the address bits from the top of the memory address range down to bit 12, and the low twelve bits are forced to zero. A badly framed erase that would otherwise have qualified is dropped and disarms the latch. Commands that do not qualify leave no other trace. The serial inputs are sampled on the system clock, so the serial clock must run several times slower than the system clock.

Top module: `sflash_se_ctrl`

## Requirements
- R1: A frame whose first 8 bits are opcode 0x06 and that ends (chip select high) after exactly 8 serial clock rising edges sets `wel_o` when `busy_o` is low. A 0x06 frame of any other length has no effect.
- R2: A frame with opcode 0x20 followed by a 24-bit address (MSB first), ending after exactly 32 rising edges while `wel_o` is 1 and `busy_o` is 0, raises `busy_o` on the first clock edge that samples chip select high.
- R3: A well-framed 0x20 command received while `wel_o` is 0 is ignored: `busy_o` stays 0, no memory write occurs and `wel_o` stays 0.
- R4: A 0x20 frame of at least 8 bits but not exactly 32 bits, received while `wel_o` is 1 and `busy_o` is 0, starts no erase and clears `wel_o`.
- R5: An accepted erase writes addresses `{addr[MEM_AW-1:12], k}` for k = 0 to 4095 in increasing order, one per clock. The first write happens in the first busy cycle.
- R6: Every memory write carries data 0xFF.
- R7: `busy_o` stays high for exactly ERASE_CYCLES clocks, and `wel_o` is cleared on the edge where `busy_o` falls.
- R8: While `busy_o` is high every frame is ignored. The erase is not restarted, and `wel_o` is not changed by any frame.
- R9: After reset `busy_o`, `wel_o` and `mem_we_o` are 0.
- R10: Frames with fewer than 8 bits, and 8-bit frames with an opcode other than 0x06 or 0x20, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, sampled on clk_i |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in, taken on serial clock rising edges |
| busy_o | output | 1 | Erase in progress |
| wel_o | output | 1 | Write-enable latch |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | MEM_AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The assertions assume that the serial inputs are synchronous to `clk_i`. They also assume that a serial clock rising edge and a chip select rise never reach the block in the same system clock. The length of every frame is therefore unambiguous. The stimulus drives all serial pins on the falling edge of `clk_i` and holds each serial clock phase for four system clocks. It returns the serial clock low and waits before raising chip select, so bit counts are exact, including the deliberately wrong 9-, 31- and 33-bit frames. Frames sent during an erase also keep to these rules, so the ignore behaviour is tested on clean framing.

// File: rtl/sflash_se_pkg.sv
package sflash_se_pkg;
  localparam int unsigned OP_W       = 8;
  localparam int unsigned ADDR_BITS  = 24;
  localparam int unsigned FRAME_BITS = OP_W + ADDR_BITS;
  localparam int unsigned SEC_AW     = 12;
  localparam int unsigned SEC_BYTES  = 1 << SEC_AW;
  localparam int unsigned BITCNT_W   = $clog2(FRAME_BITS + 2);

  localparam logic [OP_W-1:0] OP_WREN = 8'h06;
  localparam logic [OP_W-1:0] OP_SE   = 8'h20;
  localparam logic [7:0]      ERASED  = 8'hFF;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_SE_GO,
    CMD_SE_BAD
  } cmd_e;
endpackage

// File: rtl/sflash_frame_rx.sv
module sflash_frame_rx
  import sflash_se_pkg::*;
#(
  parameter int unsigned MEM_AW = 19
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sclk_i,
  input  logic                       cs_ni,
  input  logic                       si_i,
  output logic                       frame_end_o,
  output logic [OP_W-1:0]            opcode_o,
  output logic [BITCNT_W-1:0]        nbits_o,
  output logic [MEM_AW-SEC_AW-1:0]   sector_o
);
  localparam logic [BITCNT_W-1:0] CNT_SAT = BITCNT_W'(FRAME_BITS + 1);
  localparam logic [BITCNT_W-1:0] OP_LAST = BITCNT_W'(OP_W - 1);

  logic              sclk_q, cs_q;
  logic              sclk_rise;
  logic [BITCNT_W-1:0] cnt_q;
  logic [MEM_AW-1:0] sh_q;
  logic [OP_W-1:0]   op_q;

  assign sclk_rise   = sclk_i & ~sclk_q & ~cs_ni;
  assign frame_end_o = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= '0;
      op_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (cs_ni) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        sh_q <= {sh_q[MEM_AW-2:0], si_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == OP_LAST) op_q <= {sh_q[OP_W-2:0], si_i};
      end
    end
  end

  assign opcode_o = op_q;
  assign nbits_o  = cnt_q;
  assign sector_o = sh_q[MEM_AW-1:SEC_AW];
endmodule

// File: rtl/sflash_se_qualify.sv
module sflash_se_qualify
  import sflash_se_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_end_i,
  input  logic [OP_W-1:0]     opcode_i,
  input  logic [BITCNT_W-1:0] nbits_i,
  input  logic                busy_i,
  input  logic                done_i,
  output logic                start_o,
  output logic                wel_o
);
  localparam logic [BITCNT_W-1:0] N_OP    = BITCNT_W'(OP_W);
  localparam logic [BITCNT_W-1:0] N_FRAME = BITCNT_W'(FRAME_BITS);

  cmd_e cmd;
  logic wel_q, wel_d;

  always_comb begin
    cmd = CMD_NONE;
    if (frame_end_i && !busy_i && nbits_i >= N_OP) begin
      if (opcode_i == OP_WREN && nbits_i == N_OP) cmd = CMD_WREN;
      else if (opcode_i == OP_SE && wel_q)        cmd = (nbits_i == N_FRAME) ? CMD_SE_GO : CMD_SE_BAD;
    end
  end

  always_comb begin
    wel_d = wel_q;
    unique case (cmd)
      CMD_WREN:   wel_d = 1'b1;
      CMD_SE_BAD: wel_d = 1'b0;
      default:    ;
    endcase
    if (done_i) wel_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wel_q <= 1'b0;
    else         wel_q <= wel_d;
  end

  assign start_o = (cmd == CMD_SE_GO);
  assign wel_o   = wel_q;
endmodule

// File: rtl/sflash_sector_wipe.sv
module sflash_sector_wipe
  import sflash_se_pkg::*;
#(
  parameter int unsigned MEM_AW       = 19,
  parameter int unsigned ERASE_CYCLES = 5000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [MEM_AW-SEC_AW-1:0] sector_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     mem_we_o,
  output logic [MEM_AW-1:0]        mem_addr_o,
  output logic [7:0]               mem_wdata_o
);
  localparam int unsigned CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] WR_SPAN = CNT_W'(SEC_BYTES);

  logic                     busy_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [MEM_AW-SEC_AW-1:0] sec_q;

  assign done_o = busy_q && cnt_q == LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sec_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sec_q  <= sector_i;
    end else if (busy_q) begin
      if (done_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign mem_we_o    = busy_q && cnt_q < WR_SPAN;
  assign mem_addr_o  = {sec_q, cnt_q[SEC_AW-1:0]};
  assign mem_wdata_o = ERASED;
endmodule

// File: rtl/sflash_se_ctrl.sv
module sflash_se_ctrl
  import sflash_se_pkg::*;
#(
  parameter int unsigned MEM_AW       = 19,
  parameter int unsigned ERASE_CYCLES = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              si_i,
  output logic              busy_o,
  output logic              wel_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  logic                     frame_end, start, done;
  logic [OP_W-1:0]          opcode;
  logic [BITCNT_W-1:0]      nbits;
  logic [MEM_AW-SEC_AW-1:0] sector;

  sflash_frame_rx #(.MEM_AW(MEM_AW)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .si_i,
    .frame_end_o(frame_end), .opcode_o(opcode), .nbits_o(nbits), .sector_o(sector)
  );

  sflash_se_qualify u_qual (
    .clk_i, .rst_ni,
    .frame_end_i(frame_end), .opcode_i(opcode), .nbits_i(nbits),
    .busy_i(busy_o), .done_i(done), .start_o(start), .wel_o(wel_o)
  );

  sflash_sector_wipe #(.MEM_AW(MEM_AW), .ERASE_CYCLES(ERASE_CYCLES)) u_wipe (
    .clk_i, .rst_ni, .start_i(start), .sector_i(sector),
    .busy_o(busy_o), .done_o(done),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );
endmodule

// File: rtl/sflash_se_ctrl_chk.sv
module sflash_se_ctrl_chk #(
  parameter int unsigned MEM_AW       = 19,
  parameter int unsigned ERASE_CYCLES = 5000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              wel_o,
  input logic              mem_we_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  p_we_in_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);
  p_first_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_we_o && mem_addr_o[11:0] == 12'h000);
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && $past(mem_we_o) |-> mem_addr_o == $past(mem_addr_o) + 1'b1);
  p_data_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_wdata_o == 8'hFF);
  p_start_needs_wel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wel_o));
  p_busy_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == ERASE_CYCLES);
  p_wel_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !wel_o);
  p_wel_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) && busy_o |-> $stable(wel_o));
endmodule

bind sflash_se_ctrl sflash_se_ctrl_chk #(.MEM_AW(MEM_AW), .ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .wel_o(wel_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
);

// File: tb/sflash_se_ctrl_tb.sv
`timescale 1ns/1ps
module sflash_se_ctrl_tb;
  localparam int MEM_AW = 19;
  localparam int EC     = 5000;
  localparam int HALF   = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sclk_i = 1'b0, cs_ni = 1'b1, si_i = 1'b0;
  logic busy_o, wel_o, mem_we_o;
  logic [MEM_AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #2.5 clk_i = ~clk_i;

  sflash_se_ctrl #(.MEM_AW(MEM_AW), .ERASE_CYCLES(EC)) u_dut (.*);

  // behavioural reference
  bit m_busy, m_wel, psclk, pcs;
  int m_cnt, m_base;
  bit q[$];
  int wr[int];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_busy = 0; m_wel = 0; m_cnt = 0; m_base = 0;
      psclk = 0; pcs = 1; q.delete();
    end else begin
      bit ob;
      ob = m_busy;
      if (!cs_ni && sclk_i && !psclk) q.push_back(si_i);
      if (cs_ni && !pcs) begin
        if (!ob && q.size() >= 8) begin
          int op;
          op = 0;
          for (int i = 0; i < 8; i++) op = (op << 1) | q[i];
          if (op == 'h06 && q.size() == 8) m_wel = 1;
          else if (op == 'h20 && m_wel) begin
            if (q.size() == 32) begin
              int a;
              a = 0;
              for (int i = 8; i < 32; i++) a = (a << 1) | q[i];
              m_base = (a % (1 << MEM_AW)) / 4096 * 4096;
              m_busy = 1; m_cnt = 0;
            end else m_wel = 0;
          end
        end
        q.delete();
      end
      if (ob) begin
        if (m_cnt == EC - 1) begin m_busy = 0; m_wel = 0; end
        else m_cnt++;
      end
      psclk = sclk_i; pcs = cs_ni;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    bit ewe;
    ewe = m_busy && m_cnt < 4096;
    chk(busy_o == m_busy, "R2/R7/R8 busy", busy_o, m_busy);
    chk(wel_o == m_wel, "R1/R4/R7 wel", wel_o, m_wel);
    chk(mem_we_o == ewe, "R5 we", mem_we_o, ewe);
    if (mem_we_o && ewe) begin
      chk(int'(mem_addr_o) == m_base + m_cnt, "R5 addr", mem_addr_o, m_base + m_cnt);
      chk(mem_wdata_o == 8'hFF, "R6 data", mem_wdata_o, 8'hFF);
      if (wr.exists(int'(mem_addr_o))) wr[int'(mem_addr_o)]++;
      else wr[int'(mem_addr_o)] = 1;
    end
  end

  task automatic send(input logic [39:0] bits, input int n);
    @(negedge clk_i) cs_ni = 1'b0;
    repeat (HALF) @(negedge clk_i);
    for (int i = 0; i < n; i++) begin
      si_i = bits[39-i]; sclk_i = 1'b0;
      repeat (HALF) @(negedge clk_i);
      sclk_i = 1'b1;
      repeat (HALF) @(negedge clk_i);
    end
    sclk_i = 1'b0;
    repeat (HALF) @(negedge clk_i);
    cs_ni = 1'b1;
    repeat (HALF * 2) @(negedge clk_i);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic check_sector(input int base, input string req);
    chk(wr.size() == 4096, req, wr.size(), 4096);
    chk(wr.exists(base) && wr.exists(base + 4095), req, wr.exists(base), 1);
    wr.delete();
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done_flag && cyc < 150000) begin @(posedge clk_i); cyc++; end
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    chk(!busy_o && !wel_o && !mem_we_o, "R9 reset", {busy_o, wel_o, mem_we_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    send({8'h20, 24'h012345, 8'h0}, 32);            // R3 no latch
    chk(!busy_o && !wel_o && wr.size() == 0, "R3", {busy_o, wel_o}, 0);
    send({8'h06, 32'h0}, 9);                       // R1 wrong length
    chk(!wel_o, "R1 9-bit wren", wel_o, 0);
    send({8'h06, 32'h0}, 5);                       // R10 short
    chk(!wel_o, "R10 short", wel_o, 0);
    send({8'h06, 32'h0}, 8);
    chk(wel_o, "R1 wren", wel_o, 1);
    send({8'hAB, 32'h0}, 8);
    chk(wel_o, "R10 other op", wel_o, 1);
    send({8'h20, 24'h012345, 8'h0}, 31);           // R4
    chk(!wel_o && !busy_o, "R4 31-bit", {busy_o, wel_o}, 0);
    send({8'h06, 32'h0}, 8);
    send({8'h20, 24'h012345, 8'h0}, 33);
    chk(!wel_o && !busy_o, "R4 33-bit", {busy_o, wel_o}, 0);

    send({8'h06, 32'h0}, 8);
    send({8'h20, 24'h012345, 8'h0}, 32);           // R2 accepted
    chk(busy_o && wel_o, "R2 start", {busy_o, wel_o}, 3);
    send({8'h20, 24'h07F000, 8'h0}, 31);           // R8 bad frame while busy
    chk(busy_o && wel_o, "R8 busy bad", {busy_o, wel_o}, 3);
    send({8'h20, 24'h07F000, 8'h0}, 32);           // R8 restart attempt
    chk(busy_o && wel_o, "R8 busy se", {busy_o, wel_o}, 3);
    wait_idle();
    chk(!wel_o, "R7 wel cleared", wel_o, 0);
    check_sector('h12000, "R5 sector 0x12");

    send({8'h06, 32'h0}, 8);
    send({8'h20, 24'hF80FFF, 8'h0}, 32);           // top bits beyond MEM_AW dropped
    wait_idle();
    check_sector('h00000, "R5 sector 0");
    send({8'h06, 32'h0}, 8);
    send({8'h20, 24'hFFFFFF, 8'h0}, 32);
    wait_idle();
    check_sector('h7F000, "R5 last sector");
    chk(!busy_o && !wel_o, "R7 idle", {busy_o, wel_o}, 0);

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule